// File: doc/BRIEF.md
# Object Attribute Copy Engine

This block copies a fixed-length run of bytes from any CPU-visible source page into the object attribute RAM that the video logic reads. Software starts it with one write of a 16-bit base address. From then on the engine moves one byte per step. Each step reads the system bus through the normal read path and writes the byte into object RAM at a running index.

The engine paces itself with a machine-cycle clock enable. After it accepts a start, it waits a longer settling delay before the first byte. After that, each byte follows the previous one by a shorter fixed gap. A new accepted start at any time drops whatever step was pending and begins again from the new base. Start addresses above the highest legal page base are ignored.

While a copy is running, the engine raises a busy flag and a bus-lock flag that the address decoder uses to fence off the CPU. The lock drops during the cycle in which the engine performs its own read, so the engine never blocks itself. A one-cycle completion pulse follows the final byte.

Top module: `oam_copy_dma`

## Requirements
- R1: After reset the engine is idle: busy, busLock, wrEn, rdEn and done are all low.
- R2: A start with startBase at or below 0xF100 is accepted. From the next cycle busy is high, the source address is startBase, the object RAM index is 0 and 160 bytes remain.
- R3: A start with startBase above 0xF100 is ignored. An idle engine stays idle, and a running copy continues with unchanged timing, addresses and data.
- R4: Only cycles with tickEn high are counted, and the tick in the cycle of the accepted start is not counted. The first byte is written in the cycle carrying the 8th counted tick, and each later byte 4 counted ticks after the one before.
- R5: In a step cycle, rdEn and wrEn are high together, rdAddr is the source address, wrData equals rdData, and wrIdx is the index. Both source address and index then advance by one, so byte k comes from base+k and goes to index k.
- R6: busy stays high until the clock edge that completes the 160th write, and is low from the following cycle.
- R7: An accepted start while busy cancels the pending step and restarts the copy. The new copy uses the new base and index 0, and its first byte comes 8 counted ticks later.
- R8: busLock is high in every busy cycle except a step cycle, and low in a step cycle.
- R9: done is high for exactly one cycle, the cycle after the 160th write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| tickEn | input | 1 | Machine-cycle enable used for pacing |
| startValid | input | 1 | Start request strobe |
| startBase | input | 16 | Source base address for the copy |
| rdEn | output | 1 | System-bus read strobe of the engine |
| rdAddr | output | 16 | System-bus read address |
| rdData | input | 8 | Byte returned by the read path in the same cycle |
| wrEn | output | 1 | Object RAM write strobe |
| wrIdx | output | 8 | Object RAM byte index |
| wrData | output | 8 | Byte written into object RAM |
| busy | output | 1 | Copy in progress |
| busLock | output | 1 | Bus lockout for the address decoder, clear during the engine's own read |
| done | output | 1 | One-cycle completion pulse |

## Verification
The bench builds the engine with its default parameters: 160 bytes per copy, an 8-tick start delay, a 4-tick byte gap and a 0xF100 base limit. These values put whole copies within reach, including the one starting exactly at the limit page, so the last-byte edge, the completion pulse and the busy fall are all observed. Because tickEn is driven at divide ratios of one, two and three, the tick gating is exercised at more than one rate. Rejected starts are injected while idle, before the first byte and in mid-copy, and a retrigger after three bytes shows that the copy restarts from index zero.

// File: rtl/oam_dma_pkg.sv
package oam_dma_pkg;

  // strobes passed from the sequencer to the address/data path
  typedef struct packed {
    logic load;   // accepted start: reload source and index
    logic step;   // move one byte this cycle
  } dmaStrobe_t;

endpackage

// File: rtl/oam_dma_ctrl.sv
module oam_dma_ctrl
  import oam_dma_pkg::*;
#(
  parameter int ADDR_W      = 16,
  parameter int COUNT       = 160,
  parameter int FIRST_DELAY = 8,
  parameter int STEP_DELAY  = 4,
  parameter int LIMIT_BASE  = 16'hF100
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tickEn,
  input  logic              startValid,
  input  logic [ADDR_W-1:0] startBase,
  output dmaStrobe_t        strobe,
  output logic              busy,
  output logic              done
);

  localparam int WAIT_MAX = (FIRST_DELAY > STEP_DELAY) ? FIRST_DELAY : STEP_DELAY;
  localparam int WAIT_W   = $clog2(WAIT_MAX + 1);
  localparam int REM_W    = $clog2(COUNT + 1);

  logic [REM_W-1:0]  remain;
  logic [WAIT_W-1:0] waitCnt;
  logic              loadReq;
  logic              active;
  logic              stepNow;

  assign loadReq = startValid && (startBase <= ADDR_W'(LIMIT_BASE));
  assign active  = (remain != '0);
  assign stepNow = !loadReq && tickEn && active && (waitCnt == WAIT_W'(1));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      remain  <= '0;
      waitCnt <= '0;
      done    <= 1'b0;
    end else begin
      done <= stepNow && (remain == REM_W'(1));
      if (loadReq) begin
        remain  <= REM_W'(COUNT);
        waitCnt <= WAIT_W'(FIRST_DELAY);
      end else if (tickEn && active) begin
        if (waitCnt == WAIT_W'(1)) begin
          remain  <= remain - REM_W'(1);
          waitCnt <= WAIT_W'(STEP_DELAY);
        end else begin
          waitCnt <= waitCnt - WAIT_W'(1);
        end
      end
    end
  end

  assign strobe.load = loadReq;
  assign strobe.step = stepNow;
  assign busy        = active;

endmodule

// File: rtl/oam_dma_path.sv
module oam_dma_path
  import oam_dma_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter int COUNT  = 160
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  dmaStrobe_t               strobe,
  input  logic [ADDR_W-1:0]        startBase,
  output logic                     rdEn,
  output logic [ADDR_W-1:0]        rdAddr,
  input  logic [DATA_W-1:0]        rdData,
  output logic                     wrEn,
  output logic [$clog2(COUNT)-1:0] wrIdx,
  output logic [DATA_W-1:0]        wrData
);

  localparam int IDX_W = $clog2(COUNT);

  logic [ADDR_W-1:0] srcAddr;
  logic [IDX_W-1:0]  dstIdx;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      srcAddr <= '0;
      dstIdx  <= '0;
    end else if (strobe.load) begin
      srcAddr <= startBase;
      dstIdx  <= '0;
    end else if (strobe.step) begin
      srcAddr <= srcAddr + ADDR_W'(1);
      dstIdx  <= dstIdx + IDX_W'(1);
    end
  end

  assign rdEn   = strobe.step;
  assign rdAddr = srcAddr;
  assign wrEn   = strobe.step;
  assign wrIdx  = dstIdx;
  assign wrData = rdData;

endmodule

// File: rtl/oam_copy_dma.sv
module oam_copy_dma
  import oam_dma_pkg::*;
#(
  parameter int ADDR_W      = 16,
  parameter int DATA_W      = 8,
  parameter int COUNT       = 160,
  parameter int FIRST_DELAY = 8,
  parameter int STEP_DELAY  = 4,
  parameter int LIMIT_BASE  = 16'hF100
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     tickEn,
  input  logic                     startValid,
  input  logic [ADDR_W-1:0]        startBase,
  output logic                     rdEn,
  output logic [ADDR_W-1:0]        rdAddr,
  input  logic [DATA_W-1:0]        rdData,
  output logic                     wrEn,
  output logic [$clog2(COUNT)-1:0] wrIdx,
  output logic [DATA_W-1:0]        wrData,
  output logic                     busy,
  output logic                     busLock,
  output logic                     done
);

  dmaStrobe_t strobe;

  oam_dma_ctrl #(
    .ADDR_W(ADDR_W), .COUNT(COUNT), .FIRST_DELAY(FIRST_DELAY),
    .STEP_DELAY(STEP_DELAY), .LIMIT_BASE(LIMIT_BASE)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .startValid(startValid),
    .startBase(startBase), .strobe(strobe), .busy(busy), .done(done)
  );

  oam_dma_path #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .COUNT(COUNT)
  ) u_path (
    .clk(clk), .rstN(rstN), .strobe(strobe), .startBase(startBase),
    .rdEn(rdEn), .rdAddr(rdAddr), .rdData(rdData),
    .wrEn(wrEn), .wrIdx(wrIdx), .wrData(wrData)
  );

  // the engine's own read is exempt from the lockout it imposes
  assign busLock = busy && !rdEn;

endmodule

// File: rtl/oam_copy_dma_chk.sv
module oam_copy_dma_chk #(
  parameter int ADDR_W     = 16,
  parameter int IDX_W      = 8,
  parameter int LIMIT_BASE = 16'hF100
) (
  input logic              clk,
  input logic              rstN,
  input logic              startValid,
  input logic [ADDR_W-1:0] startBase,
  input logic              busy,
  input logic              busLock,
  input logic              rdEn,
  input logic              wrEn,
  input logic [IDX_W-1:0]  wrIdx,
  input logic              done
);

  // R3: an out-of-range start leaves an idle engine idle
  a_r3_reject_idle: assert property (@(posedge clk) disable iff (!rstN)
    (startValid && startBase > ADDR_W'(LIMIT_BASE) && !busy) |=> !busy);

  // R2: an accepted start makes the engine busy on the next cycle
  a_r2_accept_busy: assert property (@(posedge clk) disable iff (!rstN)
    (startValid && startBase <= ADDR_W'(LIMIT_BASE)) |=> (busy && !done));

  // R4: byte writes never occur in back-to-back cycles
  a_r4_spacing: assert property (@(posedge clk) disable iff (!rstN)
    wrEn |=> !wrEn);

  // R5: the object RAM index advances by one after each write
  a_r5_index_advance: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && !startValid) |=> (wrIdx == $past(wrIdx) + IDX_W'(1)));

  // R6: no writes while idle
  a_r6_idle_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !wrEn);

  // R8: the engine's own read cycle is not locked out
  a_r8_self_exempt: assert property (@(posedge clk) disable iff (!rstN)
    rdEn |-> !busLock);

  // R9: completion follows a write and ends the busy phase
  a_r9_done_after_last: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (!busy && $past(wrEn)));

  // R9: completion is a single-cycle pulse
  a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

endmodule

bind oam_copy_dma oam_copy_dma_chk #(
  .ADDR_W(ADDR_W), .IDX_W($clog2(COUNT)), .LIMIT_BASE(LIMIT_BASE)
) u_chk (
  .clk(clk), .rstN(rstN), .startValid(startValid), .startBase(startBase),
  .busy(busy), .busLock(busLock), .rdEn(rdEn), .wrEn(wrEn),
  .wrIdx(wrIdx), .done(done)
);

// File: tb/sim_oam_copy_dma.sv
module sim_oam_copy_dma;

  logic        clk = 1'b0;
  logic        rstN;
  logic        tickEn;
  logic        startValid;
  logic [15:0] startBase;
  logic        rdEn;
  logic [15:0] rdAddr;
  logic [7:0]  rdData;
  logic        wrEn;
  logic [7:0]  wrIdx;
  logic [7:0]  wrData;
  logic        busy;
  logic        busLock;
  logic        done;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  function automatic logic [7:0] memByte(input logic [15:0] a);
    return (a[7:0] + a[15:8]) ^ 8'h5A;
  endfunction

  assign rdData = memByte(rdAddr);

  oam_copy_dma u0 (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .startValid(startValid),
    .startBase(startBase), .rdEn(rdEn), .rdAddr(rdAddr), .rdData(rdData),
    .wrEn(wrEn), .wrIdx(wrIdx), .wrData(wrData), .busy(busy),
    .busLock(busLock), .done(done)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // base[47:32], tick divider[31:16], cycle of an ignored start[15:0] (0 = none)
  localparam logic [47:0] VEC [4] = '{
    {16'h0000, 16'd1, 16'd0},
    {16'hC000, 16'd2, 16'd40},
    {16'hF100, 16'd1, 16'd5},
    {16'h8040, 16'd3, 16'd0}
  };

  // trigger one copy and follow it to completion
  task automatic runCopy(input logic [15:0] base, input int div,
                         input int rejectCyc, input string tag);
    int tickNo = 0;
    int cyc = 0;
    int written = 0;
    int timeBad = 0;
    int dataBad = 0;
    int lockBad = 0;
    bit expWr;
    @(negedge clk);
    startValid = 1'b1; startBase = base; tickEn = 1'b0;
    @(negedge clk);
    startValid = 1'b0;
    #1;
    check(busy === 1'b1, "R2", {tag, " busy after start"}, busy, 1);
    while (written < 160 && cyc < 5000) begin
      tickEn = ((cyc % div) == div - 1);
      startValid = (rejectCyc != 0 && cyc == rejectCyc);  // R3 ignored start
      startBase = 16'hF101 + 16'(cyc);
      if (tickEn) tickNo++;
      #1;
      expWr = tickEn && tickNo >= 8 && ((tickNo - 8) % 4 == 0);
      if (wrEn !== expWr) timeBad++;
      if (wrEn === 1'b1) begin
        if (wrIdx !== 8'(written) || rdAddr !== base + 16'(written) ||
            wrData !== memByte(base + 16'(written)) || rdEn !== 1'b1)
          dataBad++;
        if (busLock !== 1'b0) lockBad++;
        written++;
      end else if (busLock !== 1'b1 || rdEn !== 1'b0) begin
        lockBad++;
      end
      cyc++;
      @(negedge clk);
    end
    tickEn = 1'b0; startValid = 1'b0;
    #1;
    check(written == 160 && timeBad == 0, "R4", {tag, " byte pacing"}, timeBad, 0);
    check(dataBad == 0, "R5", {tag, " byte source and index"}, dataBad, 0);
    check(lockBad == 0, "R8", {tag, " lock outside own read"}, lockBad, 0);
    check(done === 1'b1, "R9", {tag, " done after last byte"}, done, 1);
    check(busy === 1'b0, "R6", {tag, " busy clear after last byte"}, busy, 0);
    @(negedge clk);
    #1;
    check(done === 1'b0, "R9", {tag, " done single cycle"}, done, 0);
  endtask

  initial begin
    #(8 * 150000);
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rstN = 1'b0; tickEn = 1'b0; startValid = 1'b0; startBase = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    #1;
    // R1 reset state
    check(busy === 1'b0 && busLock === 1'b0, "R1", "busy/lock after reset", {busy, busLock}, 0);
    check(wrEn === 1'b0 && rdEn === 1'b0 && done === 1'b0, "R1", "strobes after reset",
          {wrEn, rdEn, done}, 0);

    // table walk: R2 R4 R5 R6 R8 R9, with ignored starts for R3
    for (int i = 0; i < 4; i++) begin
      runCopy(VEC[i][47:32], int'(VEC[i][31:16]), int'(VEC[i][15:0]), $sformatf("vec%0d", i));
    end

    // R3: out-of-range start while idle has no effect
    begin
      int stray = 0;
      @(negedge clk);
      startValid = 1'b1; startBase = 16'hF101; tickEn = 1'b1;
      @(negedge clk);
      startValid = 1'b0;
      for (int c = 0; c < 12; c++) begin
        #1;
        if (busy !== 1'b0 || wrEn !== 1'b0) stray++;
        @(negedge clk);
      end
      check(stray == 0, "R3", "idle start above limit ignored", stray, 0);
    end

    // R7: retrigger after three bytes restarts from index 0 with the new base
    begin
      int seen = 0;
      @(negedge clk);
      startValid = 1'b1; startBase = 16'h1234; tickEn = 1'b0;
      @(negedge clk);
      startValid = 1'b0; tickEn = 1'b1;
      for (int c = 0; c < 17; c++) begin
        #1;
        if (wrEn === 1'b1) seen++;
        @(negedge clk);
      end
      tickEn = 1'b0;
      check(seen == 3 && busy === 1'b1, "R7", "bytes before retrigger", seen, 3);
      runCopy(16'h2200, 1, 0, "R7 restart");
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule